// File: doc/BRIEF.md
# Frame-rate-control grayscale pattern engine

This block turns two-bit pixel codes into single on/off dots for a binary STN panel. It shows four apparent densities by switching mid-level pixels on and off in a spatial-temporal pattern. Code 00 is always dark and code 11 is always lit. Each of the two middle codes owns a host-programmed table of sixteen 4x4 bit patterns. A four-bit frame phase picks one pattern per frame. Within that pattern, the pixel's row and column (each taken modulo 4) pick a single bit. The same path can drive roughly four colours on a reflective birefringence colour panel.

The host fills a 64-byte pattern store through a simple byte write port. The display pipeline presents `LANES` adjacent pixels per beat, together with the row phase and the column phase of the first lane. The dots for that beat appear one clock later. A frame-start pulse steps the frame phase. Writes reach the pixel path at once, with no shadow copy.

Top module: `gfr_dither_top`

## Requirements
- R1: A pixel with code 00 yields dot 0 whatever the store holds.
- R2: A pixel with code 11 yields dot 1 whatever the store holds.
- R3: Code 01 reads table 0 (byte addresses 0..31) and code 10 reads table 1 (byte addresses 32..63).
- R4: Pattern p of table t is the 16-bit word at byte addresses t*32+2p (low byte) and t*32+2p+1 (high byte). A pixel in row r and column c uses bit 4r+c of that word. Lane k of a beat sits in column (px_col + k) mod 4.
- R5: Each cycle with `frame_mark` high steps the frame phase by one, from 15 back to 0. Pixels presented in that same cycle still use the phase from before the step.
- R6: After reset, `dot_valid` and `dot_out` are 0 and the frame phase is 0.
- R7: The dots for a beat presented with `px_valid` high appear on the next clock with `dot_valid` high. A cycle with `px_valid` low gives `dot_valid` low on the next clock and leaves `dot_out` unchanged.
- R8: A store write lands at the clock edge. A pixel presented in the same cycle as the write sees the old byte, and a pixel presented in any later cycle sees the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Pattern store byte write enable |
| cfg_addr | input | AW (6) | Pattern store byte address |
| cfg_wdata | input | 8 | Pattern store write data |
| frame_mark | input | 1 | First-line pulse; steps the frame phase |
| px_valid | input | 1 | Pixel beat valid |
| px_row | input | 2 | Line number modulo 4 |
| px_col | input | 2 | Column modulo 4 of lane 0 |
| px_level | input | 2*LANES (8) | Pixel codes, lane k in bits [2k+1:2k] |
| dot_valid | output | 1 | Dots valid |
| dot_out | output | LANES (4) | On/off dots, lane k in bit k |

## Verification
The bench builds the block with its defaults: four lanes per beat and sixteen patterns per table. With four lanes, a single beat spans every column phase at once. Moving the lane-0 column offset then walks the column wrap through each lane position. Sixteen patterns keep the frame wrap from 15 to 0 within a few dozen beats. As a result the bench can step through every row, every column offset and every phase, reach the wrap, and overwrite the pattern in use in the middle of a stream.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'b00,
    LVL_MID_A = 2'b01,
    LVL_MID_B = 2'b10,
    LVL_ON    = 2'b11
  } gfr_level_e;

  // pick the bit for a pixel inside a 4x4 pattern word (row-major, bit 4r+c)
  function automatic logic pat_bit(input logic [15:0] word,
                                   input logic [1:0] row,
                                   input logic [1:0] col);
    return word[{row, col}];
  endfunction

endpackage

// File: rtl/gfr_rst_sync.sv
module gfr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/gfr_phase_ctr.sv
module gfr_phase_ctr #(
  parameter int PATTERNS = 16,
  localparam int PHW = $clog2(PATTERNS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  output logic [PHW-1:0] phase
);
  localparam logic [PHW-1:0] LAST = PHW'(PATTERNS - 1);

  logic [PHW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (advance) begin
      if (phase_q == LAST) phase_d = '0;
      else                 phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/gfr_pattern_store.sv
module gfr_pattern_store #(
  parameter int PATTERNS = 16,
  localparam int PHW   = $clog2(PATTERNS),
  localparam int AW    = PHW + 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  input  logic [PHW-1:0] phase,
  output logic [15:0]    word_a,
  output logic [15:0]    word_b
);
  logic [7:0] mem_q [DEPTH];

  // storage has no reset: contents are defined by host writes only
  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  logic [AW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, phase, 1'b0};
    a_hi = {1'b0, phase, 1'b1};
    b_lo = {1'b1, phase, 1'b0};
    b_hi = {1'b1, phase, 1'b1};
    word_a = {mem_q[a_hi], mem_q[a_lo]};
    word_b = {mem_q[b_hi], mem_q[b_lo]};
  end
endmodule

// File: rtl/gfr_lane.sv
module gfr_lane
  import gfr_pkg::*;
(
  input  logic [1:0]  level,
  input  logic [1:0]  row,
  input  logic [1:0]  col,
  input  logic [15:0] word_a,
  input  logic [15:0] word_b,
  output logic        dot
);
  gfr_level_e lvl;

  always_comb begin
    lvl = gfr_level_e'(level);
    unique case (lvl)
      LVL_OFF:   dot = 1'b0;
      LVL_MID_A: dot = pat_bit(word_a, row, col);
      LVL_MID_B: dot = pat_bit(word_b, row, col);
      LVL_ON:    dot = 1'b1;
      default:   dot = 1'b0;
    endcase
  end
endmodule

// File: rtl/gfr_dither_top.sv
module gfr_dither_top #(
  parameter int LANES    = 4,
  parameter int PATTERNS = 16,
  localparam int PHW = $clog2(PATTERNS),
  localparam int AW  = PHW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic               frame_mark,
  input  logic               px_valid,
  input  logic [1:0]         px_row,
  input  logic [1:0]         px_col,
  input  logic [2*LANES-1:0] px_level,
  output logic               dot_valid,
  output logic [LANES-1:0]   dot_out
);
  logic           rst_q_n;
  logic [PHW-1:0] phase_q;
  logic [15:0]    word_a, word_b;
  logic [LANES-1:0] dot_d;

  gfr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  gfr_phase_ctr #(.PATTERNS(PATTERNS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .advance (frame_mark),
    .phase   (phase_q)
  );

  gfr_pattern_store #(.PATTERNS(PATTERNS)) u_store (
    .clk    (clk),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .phase  (phase_q),
    .word_a (word_a),
    .word_b (word_b)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] col_k;
    assign col_k = 2'(px_col + 2'(k));
    gfr_lane u_lane (
      .level  (px_level[2*k +: 2]),
      .row    (px_row),
      .col    (col_k),
      .word_a (word_a),
      .word_b (word_b),
      .dot    (dot_d[k])
    );
  end

  logic               vld_q;
  logic [LANES-1:0]   dot_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      dot_q <= '0;
    end else begin
      vld_q <= px_valid;
      if (px_valid) dot_q <= dot_d;
    end
  end

  assign dot_valid = vld_q;
  assign dot_out   = dot_q;
endmodule

// File: rtl/gfr_dither_chk.sv
module gfr_dither_chk #(
  parameter int LANES    = 4,
  parameter int PATTERNS = 16,
  localparam int PHW = $clog2(PATTERNS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_mark,
  input logic               px_valid,
  input logic [2*LANES-1:0] px_level,
  input logic               dot_valid,
  input logic [LANES-1:0]   dot_out,
  input logic [PHW-1:0]     phase
);
  localparam logic [PHW-1:0] LAST = PHW'(PATTERNS - 1);

  logic [LANES-1:0] off_mask, on_mask;
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      off_mask[k] = (px_level[2*k +: 2] == 2'b00);
      on_mask[k]  = (px_level[2*k +: 2] == 2'b11);
    end
  end

  assert_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> ((dot_out & $past(off_mask)) == '0));

  assert_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> ((dot_out & $past(on_mask)) == $past(on_mask)));

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> (phase == (($past(phase) == LAST) ? '0 : PHW'($past(phase) + 1'b1))));

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_mark |=> $stable(phase));

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> dot_valid);

  assert_hold_dots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> (!dot_valid && $stable(dot_out)));
endmodule

bind gfr_dither_top gfr_dither_chk #(.LANES(LANES), .PATTERNS(PATTERNS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .frame_mark (frame_mark),
  .px_valid   (px_valid),
  .px_level   (px_level),
  .dot_valid  (dot_valid),
  .dot_out    (dot_out),
  .phase      (phase_q)
);

// File: tb/sim_gfr_dither_top.sv
module sim_gfr_dither_top;
  localparam int LANES = 4;
  localparam int PATTERNS = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [5:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic frame_mark, px_valid;
  logic [1:0] px_row, px_col;
  logic [7:0] px_level;
  logic dot_valid;
  logic [3:0] dot_out;

  always #2 clk = ~clk;

  gfr_dither_top #(.LANES(LANES), .PATTERNS(PATTERNS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_mark(frame_mark), .px_valid(px_valid),
    .px_row(px_row), .px_col(px_col), .px_level(px_level),
    .dot_valid(dot_valid), .dot_out(dot_out)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] mdl_mem [64];
  int mdl_phase = 0;
  logic [3:0] prev_dots = 4'b0;

  function automatic logic exp_dot(input logic [1:0] lv, input int row, input int col);
    logic [15:0] w;
    int base;
    if (lv == 2'b00) return 1'b0;
    if (lv == 2'b11) return 1'b1;
    base = (lv == 2'b01 ? 0 : 32) + 2 * mdl_phase;
    w = {mdl_mem[base + 1], mdl_mem[base]};
    return w[4 * row + col];
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frame_mark = 0;
    px_valid = 0; px_row = 0; px_col = 0; px_level = 0;
  endtask

  // one cycle: drive at negedge, check dots at the following negedge
  task automatic beat(input string tag, input logic v, input logic mk,
                      input logic [1:0] r, input logic [1:0] c, input logic [7:0] lv,
                      input logic we, input logic [5:0] wa, input logic [7:0] wd);
    logic [3:0] exp;
    exp = prev_dots;
    if (v)
      for (int k = 0; k < 4; k++) exp[k] = exp_dot(lv[2*k +: 2], int'(r), (int'(c) + k) % 4);
    px_valid = v; frame_mark = mk; px_row = r; px_col = c; px_level = lv;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    @(negedge clk);
    check(tag, {dot_valid, dot_out}, {v, exp});
    prev_dots = exp;
    if (we) mdl_mem[wa] = wd;
    if (mk) mdl_phase = (mdl_phase + 1) % PATTERNS;
    idle();
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R6 reset", {dot_valid, dot_out}, 5'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R6 after release", {dot_valid, dot_out}, 5'b0);
  endtask

  task automatic t_load();
    for (int a = 0; a < 64; a++)
      beat("R7 idle during load", 0, 0, 0, 0, 0, 1, 6'(a), 8'($urandom));
  endtask

  task automatic t_solid();
    beat("R1 all dark", 1, 0, 2'd1, 2'd2, 8'h00, 0, 0, 0);
    beat("R2 all lit", 1, 0, 2'd3, 2'd0, 8'hFF, 0, 0, 0);
    beat("R1 R2 mixed", 1, 0, 2'd2, 2'd1, 8'b11_00_00_11, 0, 0, 0);
    beat("R6 phase zero", 1, 0, 2'd0, 2'd0, 8'b01_01_10_10, 0, 0, 0);
  endtask

  task automatic t_mid();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        beat("R3 table A", 1, 0, 2'(r), 2'(c), 8'h55, 0, 0, 0);
        beat("R3 table B", 1, 0, 2'(r), 2'(c), 8'hAA, 0, 0, 0);
        beat("R4 lane columns", 1, 0, 2'(r), 2'(c), 8'($urandom), 0, 0, 0);
      end
  endtask

  task automatic t_frames();
    for (int f = 0; f < 20; f++) begin
      beat("R5 marker cycle", 1, 1, 2'(f), 2'(f + 1), 8'h5A, 0, 0, 0);
      beat("R5 new phase", 1, 0, 2'(f + 2), 2'(f), 8'hA5, 0, 0, 0);
    end
  endtask

  task automatic t_write_vis();
    int lo;
    lo = 2 * mdl_phase;
    beat("R8 same cycle old", 1, 0, 2'd0, 2'd0, 8'h55, 1, 6'(lo), ~mdl_mem[lo]);
    beat("R8 next cycle new", 1, 0, 2'd0, 2'd0, 8'h55, 0, 0, 0);
    beat("R8 table B write", 1, 0, 2'd2, 2'd1, 8'hAA, 1, 6'(32 + lo + 1), ~mdl_mem[32 + lo + 1]);
    beat("R8 table B new", 1, 0, 2'd2, 2'd1, 8'hAA, 0, 0, 0);
  endtask

  task automatic t_hold();
    beat("R7 hold", 0, 0, 2'd1, 2'd1, 8'hFF, 0, 0, 0);
    beat("R7 hold again", 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 0);
    beat("R7 resume", 1, 0, 2'd3, 2'd3, 8'h1B, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_solid();
    t_mid();
    t_frames();
    t_write_vis();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule